// File: doc/BRIEF.md
# Single-Precision Round-to-Integral Unit

This block takes one IEEE 754 single-precision operand and returns the integral value it rounds to, still encoded as a single-precision number. Four rounding modes are available: nearest with ties to even, toward zero, toward plus infinity and toward minus infinity. The result is registered. It appears together with an inexact flag and an invalid-operation flag one clock after the operand is presented with its valid strobe.

Internally the operand is first classified: NaNs, infinities, zeros and denormals; values large enough to be integral already; magnitudes under one half; and the general case. For the general case a round bit and a sticky bit are taken at the binary point, and the integer part is incremented or not according to the mode. The integer is then renormalised into single-precision form and the input sign is put back on it. As a result, small negative inputs that round to nothing come out as negative zero.

Top module: `fp_rint_unit`

## Requirements
- R1: Mode code 2'b00 selects round to nearest. The integer part is incremented when the discarded fraction exceeds one half, or equals one half exactly and the integer part is odd (2.5 gives 2.0, 3.5 gives 4.0).
- R2: Mode 2'b01 (toward zero) never increments. Mode 2'b10 (toward plus infinity) increments a positive operand with a nonzero discarded fraction. Mode 2'b11 (toward minus infinity) does the same for a negative operand.
- R3: A signalling NaN (exponent field all ones, nonzero fraction, fraction bit 22 clear) yields 0x7FC00000 with the invalid flag set and the inexact flag clear.
- R4: A quiet NaN (fraction bit 22 set), an infinity or a zero is returned bit for bit, with both flags clear.
- R5: A denormal operand (exponent field 0, nonzero fraction) yields a zero that keeps the operand's sign, with both flags clear.
- R6: An operand whose unbiased exponent is 23 or more (exponent field 150 or above) is returned unchanged, with both flags clear.
- R7: A normal operand with magnitude below one half (exponent field below 126) has a zero integer part and a zero round bit, and counts as having a nonzero remainder. In nearest mode it therefore rounds to zero.
- R8: For finite normal operands below 2^23 in magnitude, the inexact flag is set exactly when the discarded fraction is nonzero.
- R9: The sign of every non-NaN result equals the operand sign, including zero results: -0.3 to nearest gives 0x80000000.
- R10: After reset the result, the valid output and both flags are 0. The valid output and the flags for an operand appear exactly one clock after its input-valid cycle.
- R11: In a cycle after input-valid was low, the valid output and both flags are low and the result holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opIn | input | 32 | Single-precision operand |
| rmIn | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| inValid | input | 1 | Operand valid strobe |
| resultOut | output | 32 | Rounded single-precision result |
| outValid | output | 1 | Result valid, one clock after inValid |
| inexactOut | output | 1 | Discarded fraction was nonzero |
| invalidOut | output | 1 | Operand was a signalling NaN |

## Verification
The bench sweeps every exponent value with both signs, all four modes and a set of fractions. Some fractions are placed on the round position itself, so that exact halves with odd and even integer parts appear at every shift distance. A design that rounds ties away from zero would return 3.0 for 2.5, and one that takes the round bit one place off would misround at each exponent. Exponent fields 125, 126, 149 and 150 are the edges where a shift-range or path-select bug would garble the result or raise inexact on an already integral value. The NaN, denormal and negative-tiny cases target a unit that loses the sign on a zero result, propagates a signalling NaN without quieting it, or treats a denormal as a tiny normal and flags it inexact.

// File: rtl/rint_pkg.sv
package rint_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int W       = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int SHAMT_W = $clog2(SIG_W + 1);
  localparam logic [W-1:0] QNAN_CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rmodeT;

  typedef struct packed {
    logic load;
    logic snan;
    logic qnan;
    logic pass;
    logic flush;
    logic tiny;
  } ctlStrobesT;
endpackage

// File: rtl/rint_msb_find.sv
module rint_msb_find #(
  parameter int IN_W  = 24,
  parameter int POS_W = 5
) (
  input  logic [IN_W-1:0]  vec,
  output logic [POS_W-1:0] pos,
  output logic             any
);
  logic [POS_W-1:0] stagePos [IN_W+1];

  assign stagePos[0] = '0;
  for (genvar i = 0; i < IN_W; i++) begin : g_scan
    assign stagePos[i+1] = vec[i] ? POS_W'(i) : stagePos[i];
  end

  assign pos = stagePos[IN_W];
  assign any = |vec;
endmodule

// File: rtl/rint_ctrl.sv
module rint_ctrl
  import rint_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op,
  input  logic         inValid,
  output ctlStrobesT   ctl,
  output logic         outValidQ
);
  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic              expMax;
  logic              fracNz;
  logic              isNan;

  assign expField  = op[W-2:FRAC_W];
  assign fracField = op[FRAC_W-1:0];
  assign expMax    = &expField;
  assign fracNz    = |fracField;
  assign isNan     = expMax && fracNz;

  always_comb begin
    ctl       = '0;
    ctl.load  = inValid;
    ctl.snan  = isNan && !fracField[FRAC_W-1];
    ctl.qnan  = isNan && fracField[FRAC_W-1];
    ctl.pass  = (expMax && !ctl.snan) ||
                ({1'b0, expField} >= (EXP_W+1)'(BIAS + FRAC_W));
    ctl.flush = (expField == '0);
    ctl.tiny  = ({1'b0, expField} < (EXP_W+1)'(BIAS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) outValidQ <= 1'b0;
    else     outValidQ <= inValid;
  end

  // R10
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValidQ);
  // R11
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValidQ);
endmodule

// File: rtl/rint_datapath.sv
module rint_datapath
  import rint_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op,
  input  logic [1:0]   rm,
  input  ctlStrobesT   ctl,
  output logic [W-1:0] resultQ,
  output logic         inexactQ,
  output logic         invalidQ
);
  logic               sign;
  logic [EXP_W-1:0]   expField;
  logic [SIG_W:0]     sigX;
  logic [EXP_W:0]     shamtWide;
  logic [SHAMT_W-1:0] shamt;
  logic [SIG_W:0]     oneX;
  logic [SIG_W:0]     tail;
  logic [SIG_W:0]     halfX;
  logic [SIG_W-1:0]   intPart;
  logic               roundBit;
  logic               stickyBit;
  logic               incr;
  logic [SIG_W-1:0]   sum;
  logic [SHAMT_W-1:0] msbPos;
  logic               sumNz;
  logic [SIG_W-1:0]   normShift;
  logic [EXP_W-1:0]   expNorm;
  logic [W-1:0]       rounded;
  logic [W-1:0]       resultNext;
  logic               inexactNext;

  assign sign      = op[W-1];
  assign expField  = op[W-2:FRAC_W];
  assign sigX      = {2'b01, op[FRAC_W-1:0]};
  assign shamtWide = (EXP_W+1)'(BIAS + FRAC_W) - {1'b0, expField};
  assign shamt     = shamtWide[SHAMT_W-1:0];
  assign oneX      = (SIG_W+1)'(1);
  assign tail      = sigX & ((oneX << shamt) - oneX);
  assign halfX     = oneX << (shamt - SHAMT_W'(1));

  always_comb begin
    if (ctl.tiny) begin
      intPart   = '0;
      roundBit  = 1'b0;
      stickyBit = 1'b1;
    end else begin
      intPart   = SIG_W'(sigX >> shamt);
      roundBit  = |(tail & halfX);
      stickyBit = |(tail & (halfX - oneX));
    end
  end

  always_comb begin
    unique case (rmodeT'(rm))
      RM_NEAR: incr = roundBit && (stickyBit || intPart[0]);
      RM_ZERO: incr = 1'b0;
      RM_UP:   incr = (roundBit || stickyBit) && !sign;
      RM_DOWN: incr = (roundBit || stickyBit) && sign;
      default: incr = 1'b0;
    endcase
  end

  assign sum = intPart + SIG_W'(incr);

  rint_msb_find #(.IN_W(SIG_W), .POS_W(SHAMT_W)) u_msb (
    .vec (sum),
    .pos (msbPos),
    .any (sumNz)
  );

  assign normShift = sum << (SHAMT_W'(FRAC_W) - msbPos);
  assign expNorm   = EXP_W'(BIAS) + EXP_W'(msbPos);
  assign rounded   = sumNz ? {sign, expNorm, normShift[FRAC_W-1:0]}
                           : {sign, {(W-1){1'b0}}};

  always_comb begin
    inexactNext = 1'b0;
    if (ctl.snan)       resultNext = QNAN_CANON;
    else if (ctl.pass)  resultNext = op;
    else if (ctl.flush) resultNext = {sign, {(W-1){1'b0}}};
    else begin
      resultNext  = rounded;
      inexactNext = roundBit || stickyBit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resultQ  <= '0;
      inexactQ <= 1'b0;
      invalidQ <= 1'b0;
    end else if (ctl.load) begin
      resultQ  <= resultNext;
      inexactQ <= inexactNext;
      invalidQ <= ctl.snan;
    end else begin
      inexactQ <= 1'b0;
      invalidQ <= 1'b0;
    end
  end

  // R3
  flag_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(inexactQ && invalidQ));
  // R9
  sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && !ctl.snan && !ctl.qnan) |=> (resultQ[W-1] == $past(op[W-1])));
  // R2
  toward_zero_mag_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && rm == 2'b01 && !ctl.snan && !ctl.qnan) |=>
      (resultQ[W-2:0] <= $past(op[W-2:0])));
  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.load |=> $stable(resultQ));
endmodule

// File: rtl/fp_rint_unit.sv
module fp_rint_unit
  import rint_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] opIn,
  input  logic [1:0]  rmIn,
  input  logic        inValid,
  output logic [31:0] resultOut,
  output logic        outValid,
  output logic        inexactOut,
  output logic        invalidOut
);
  ctlStrobesT ctl;

  rint_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .op        (opIn),
    .inValid   (inValid),
    .ctl       (ctl),
    .outValidQ (outValid)
  );

  rint_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .op       (opIn),
    .rm       (rmIn),
    .ctl      (ctl),
    .resultQ  (resultOut),
    .inexactQ (inexactOut),
    .invalidQ (invalidOut)
  );

  // R3
  quiet_nan_out_chk: assert property (@(posedge clk) disable iff (rst)
    invalidOut |-> (outValid && resultOut == 32'h7FC0_0000));
  // R11
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (inexactOut || invalidOut) |-> outValid);
endmodule

// File: tb/fp_rint_unit_bench.sv
module fp_rint_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] opIn;
  logic [1:0]  rmIn;
  logic        inValid;
  logic [31:0] resultOut;
  logic        outValid;
  logic        inexactOut;
  logic        invalidOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fp_rint_unit u_fp_rint_unit (
    .clk(clk), .rst(rst), .opIn(opIn), .rmIn(rmIn), .inValid(inValid),
    .resultOut(resultOut), .outValid(outValid),
    .inexactOut(inexactOut), .invalidOut(invalidOut)
  );

  task automatic check(string tag, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected {result, inexact, invalid} from arithmetic on the value
  function automatic logic [33:0] model(logic [31:0] op, logic [1:0] rm);
    logic s;
    int e, f, sig, sh, q, r, half, p, fr;
    bit gt, eq, nz, up;
    s = op[31];
    e = int'(op[30:23]);
    f = int'(op[22:0]);
    if (e == 255) begin
      if (f == 0) return {op, 2'b00};
      if (op[22] == 1'b0) return {32'h7FC0_0000, 2'b01};
      return {op, 2'b00};
    end
    if (e == 0) return {s, 31'd0, 2'b00};
    if (e >= 150) return {op, 2'b00};
    sig = f + (1 << 23);
    if (e < 126) begin
      q = 0; gt = 0; eq = 0; nz = 1;
    end else begin
      sh = 150 - e;
      q = sig / (1 << sh);
      r = sig % (1 << sh);
      half = 1 << (sh - 1);
      gt = (r > half); eq = (r == half); nz = (r != 0);
    end
    case (rm)
      2'b00: up = gt || (eq && (q % 2 == 1));
      2'b01: up = 0;
      2'b10: up = nz && !s;
      default: up = nz && s;
    endcase
    if (up) q = q + 1;
    if (q == 0) return {s, 31'd0, nz, 1'b0};
    p = 0;
    for (int k = 0; k < 25; k++) if (q >= (1 << k)) p = k;
    fr = (q - (1 << p)) * (1 << (23 - p));
    return {s, 8'(127 + p), 23'(fr), nz, 1'b0};
  endfunction

  function automatic int pattern(int e, int pi);
    int sh;
    case (pi)
      0: return 0;
      1: return 1;
      2: return 32'h400000;
      3: return 32'h3FFFFF;
      4: return 32'h7FFFFF;
      5: return 32'h200000;
      6: return 32'h555555;
      7: return 32'h2AAAAA;
      8: begin
        sh = 149 - e;
        if (sh >= 0 && sh <= 22) return 1 << sh;
        return 32'h100000;
      end
      default: begin
        sh = 150 - e;
        if (sh >= 1 && sh <= 22) return (1 << sh) | (1 << (sh - 1));
        return 32'h0C0000;
      end
    endcase
  endfunction

  function automatic string tagFor(logic [31:0] op, logic [1:0] rm);
    int e = int'(op[30:23]);
    if (e == 255 && op[22:0] != 0 && !op[22]) return "R3";
    if (e == 255 || op[30:0] == 0) return "R4";
    if (e == 0) return "R5";
    if (e >= 150) return "R6";
    if (e < 126) return "R7";
    if (rm == 2'b00) return "R1";
    return "R2";
  endfunction

  // drive at negedge, sample at the following negedge
  task automatic apply(logic [31:0] op, logic [1:0] rm, string tag);
    logic [33:0] exp;
    opIn = op; rmIn = rm; inValid = 1'b1;
    @(negedge clk);
    exp = model(op, rm);
    check(tag, {resultOut, inexactOut, invalidOut}, exp);
    check("R10 valid", {33'd0, outValid}, 34'd1);
    if (op[30:23] != 8'hFF || op[22:0] == 0) begin
      check("R9 sign", {33'd0, resultOut[31]}, {33'd0, op[31]});
      if (op[30:23] != 0 && op[30:23] < 8'd150)
        check("R8 inexact", {33'd0, inexactOut}, {33'd0, exp[1]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    rst = 1'b1; opIn = '0; rmIn = '0; inValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset", {resultOut, outValid, inexactOut}, 34'd0);
    check("R10 reset inv", {33'd0, invalidOut}, 34'd0);
    rst = 1'b0;
    @(negedge clk);

    // named corner cases
    apply(32'hBE99_999A, 2'b00, "R9 neg small to -0");
    check("R9 -0.3", {resultOut, inexactOut, invalidOut}, {32'h8000_0000, 2'b10});
    apply(32'h4020_0000, 2'b00, "R1 2.5");
    check("R1 2.5 to 2", {resultOut, 2'b00}, {32'h4000_0000, 2'b00});
    apply(32'h4060_0000, 2'b00, "R1 3.5");
    check("R1 3.5 to 4", {resultOut, 2'b00}, {32'h4080_0000, 2'b00});
    apply(32'h7F80_0001, 2'b00, "R3 snan");
    apply(32'h0000_0001, 2'b10, "R5 denorm");
    apply(32'h3F00_0000, 2'b00, "R1 half");

    // sweep
    for (int e = 0; e < 256; e++)
      for (int pi = 0; pi < 10; pi++)
        for (int s = 0; s < 2; s++)
          for (int m = 0; m < 4; m++) begin
            logic [31:0] op;
            op = {1'(s), 8'(e), 23'(pattern(e, pi))};
            apply(op, 2'(m), tagFor(op, 2'(m)));
          end

    // idle cycle: outputs quiet, result held
    held = resultOut;
    opIn = 32'h7F80_0001; inValid = 1'b0;
    @(negedge clk);
    check("R11 idle flags", {32'd0, outValid, inexactOut}, 34'd0);
    check("R11 idle inv", {33'd0, invalidOut}, 34'd0);
    check("R11 hold", {resultOut, 2'b00}, {held, 2'b00});
    apply(32'h3FC0_0000, 2'b11, "R2 1.5 down");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule